// File: doc/BRIEF.md
# Interlaced Video Field Detector

This block tells an even field from an odd field in an interlaced video signal. It counts clock cycles from the active edge of the horizontal sync input to the active edge of the vertical sync input. It then compares that count with the one captured during the previous field. A longer interval marks an even field and a shorter one marks an odd field. The result is published only when vertical sync ends, so that the field flag is steady for the whole visible part of the field.

An 8-bit control register sets the polarity of both sync inputs and the output polarity of the colour outputs and the two auxiliary outputs. It also holds a dot-line select bit and shows the field flag as a read-only bit. The dot-line output tells display logic with a half-line vertical dot size whether to show line 0 or line 1 of each dot row. It equals the field flag inverted or not by the select bit, so the two lines alternate from field to field.

Top module: `field_detector`

## Requirements
- R1: Control bit 0 sets the polarity of the horizontal sync input and bit 1 sets that of the vertical sync input. With the bit at 0 the input is active high and its rising edge is the active edge. With the bit at 1 the input is active low and its falling edge is the active edge. Field detection behaves the same under either setting.
- R2: An internal cycle counter is cleared on every active horizontal sync edge and counts clock cycles from then on. The value it holds at the active vertical sync edge is that field's interval.
- R3: At the active vertical sync edge the interval is compared with the interval stored for the previous field. Greater means even (flag 0), smaller means odd (flag 1), and equal keeps the current flag. The new interval always replaces the stored one. The stored interval is 0 after reset.
- R4: The field flag changes only on the trailing edge of vertical sync, the rising edge for an active-low input. While vertical sync is active after a comparison, the flag still shows the previous result.
- R5: Bit 7 of reg_rdata is the field flag (0 even, 1 odd) and always equals the field_odd output. Writes to bit 7 have no effect.
- R6: dot_line equals field_odd XOR control bit 6. Control bit 6 has no effect on field_odd or on bit 7 of reg_rdata.
- R7: After reset reg_rdata reads 8'h80. Bit 3 is reserved and always reads 0, whatever is written.
- R8: The counter saturates at 2**CNT_W-1 and does not wrap. Two intervals that both reach saturation compare as equal.
- R9: rgb_out is rgb_in XOR control bit 2 on every bit. aux_out[0] is aux_in[0] XOR control bit 4 and aux_out[1] is aux_in[1] XOR control bit 5. These paths are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel or system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync pin, asynchronous |
| vsync_in | input | 1 | Vertical sync pin, asynchronous |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data, bit 7 is the field flag |
| field_odd | output | 1 | Field flag: 1 odd, 0 even |
| dot_line | output | 1 | Dot line to show in this field |
| rgb_in | input | 3 | Colour signals before polarity |
| rgb_out | output | 3 | Colour signals after polarity |
| aux_in | input | 2 | Auxiliary signals before polarity |
| aux_out | output | 2 | Auxiliary signals after polarity |

## Verification
A wrong stored interval or a wrong counter value does not show at the ports when it occurs. It shows one field later, as a wrong field_odd, bit 7 and dot_line just after the next vertical sync trailing edge, so every check is taken after that edge and also once in the middle of vertical sync. A counter that wraps instead of saturating turns a long gap between syncs into a short one, and the flag goes odd where it should hold. A flag that updates at the comparison instead of at the trailing edge shows in the mid-sync sample. The polarity settings and the reserved bit show at once on reg_rdata and on the output pins.

// File: rtl/fd_pkg.sv
package fd_pkg;
    localparam int HPOL_BIT    = 0;
    localparam int VPOL_BIT    = 1;
    localparam int RGBPOL_BIT  = 2;
    localparam int AUX0POL_BIT = 4;
    localparam int AUX1POL_BIT = 5;
    localparam int DOTSEL_BIT  = 6;
    localparam int CTRL_W      = 7;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 7'b000_0000;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 7'b111_0111;
endpackage

// File: rtl/fd_sync_edge.sv
module fd_sync_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol_low,
    output logic [N-1:0] lead,
    output logic [N-1:0] trail
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] act;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] norm;

    always_comb begin
        norm      = st_q.s2 ^ pol_low;
        st_d      = st_q;
        st_d.s1   = raw;
        st_d.s2   = st_q.s1;
        st_d.act  = norm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign lead[i]  =  norm[i] & ~st_q.act[i];
        assign trail[i] = ~norm[i] &  st_q.act[i];
    end
endmodule

// File: rtl/fd_interval.sv
module fd_interval #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_lead,
    input  logic             vs_lead,
    input  logic             vs_trail,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             field_odd
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] stored;
        logic             pending;
        logic             flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hs_lead)
            st_d.cnt = '0;
        else if (st_q.cnt != CNT_MAX)
            st_d.cnt = st_q.cnt + 1'b1;

        if (vs_lead) begin
            st_d.stored = st_q.cnt;
            if (st_q.cnt > st_q.stored)
                st_d.pending = 1'b0;
            else if (st_q.cnt < st_q.stored)
                st_d.pending = 1'b1;
            else
                st_d.pending = st_q.flag;
        end

        if (vs_trail)
            st_d.flag = st_q.pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.stored  <= '0;
            st_q.pending <= 1'b1;
            st_q.flag    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_cnt  = st_q.cnt;
    assign field_odd = st_q.flag;
endmodule

// File: rtl/fd_ctrl_reg.sv
module fd_ctrl_reg
    import fd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [CTRL_W-1:0] ctrl
);
    typedef struct packed {
        logic [CTRL_W-1:0] bits;
    } st_t;

    st_t  st_d, st_q;
    logic unused_wdata7;

    assign unused_wdata7 = wdata[7];

    always_comb begin
        st_d = st_q;
        if (we)
            st_d.bits = wdata[CTRL_W-1:0] & CTRL_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= CTRL_RESET;
        else        st_q      <= st_d;
    end

    assign ctrl = st_q.bits;
endmodule

// File: rtl/field_detector.sv
module field_detector
    import fd_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_in,
    input  logic       vsync_in,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       field_odd,
    output logic       dot_line,
    input  logic [2:0] rgb_in,
    output logic [2:0] rgb_out,
    input  logic [1:0] aux_in,
    output logic [1:0] aux_out
);
    localparam int NSYNC = 2;

    logic [CTRL_W-1:0] ctrl;
    logic [NSYNC-1:0]  lead, trail;
    logic              hs_lead, vs_lead, vs_trail;
    logic [CNT_W-1:0]  meas_cnt;
    logic              unused_hs_trail;

    fd_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    fd_sync_edge #(.N(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     ({vsync_in, hsync_in}),
        .pol_low ({ctrl[VPOL_BIT], ctrl[HPOL_BIT]}),
        .lead    (lead),
        .trail   (trail)
    );

    assign hs_lead         = lead[0];
    assign vs_lead         = lead[1];
    assign vs_trail        = trail[1];
    assign unused_hs_trail = trail[0];

    fd_interval #(.CNT_W(CNT_W)) u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_lead   (hs_lead),
        .vs_lead   (vs_lead),
        .vs_trail  (vs_trail),
        .meas_cnt  (meas_cnt),
        .field_odd (field_odd)
    );

    always_comb begin
        reg_rdata  = {field_odd, ctrl};
        dot_line   = field_odd ^ ctrl[DOTSEL_BIT];
        rgb_out    = rgb_in ^ {3{ctrl[RGBPOL_BIT]}};
        aux_out[0] = aux_in[0] ^ ctrl[AUX0POL_BIT];
        aux_out[1] = aux_in[1] ^ ctrl[AUX1POL_BIT];
    end
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_lead,
    input logic             vs_trail,
    input logic [CNT_W-1:0] meas_cnt,
    input logic             field_odd,
    input logic             dot_line,
    input logic [7:0]       reg_rdata,
    input logic [2:0]       rgb_in,
    input logic [2:0]       rgb_out,
    input logic [1:0]       aux_in,
    input logic [1:0]       aux_out
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hs_lead |=> (meas_cnt == '0)); // R2

    AST_FLAG_ON_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (field_odd != $past(field_odd)) |-> $past(vs_trail)); // R4

    AST_FLAG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] == field_odd); // R5

    AST_DOT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        dot_line == (field_odd ^ reg_rdata[6])); // R6

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] == 1'b0); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_cnt == CNT_TOP && !hs_lead) |=> (meas_cnt == CNT_TOP)); // R8

    AST_RGB_POL: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_out == (rgb_in ^ {3{reg_rdata[2]}})); // R9

    AST_AUX_POL: assert property (@(posedge clk) disable iff (!rst_n)
        aux_out == (aux_in ^ {reg_rdata[5], reg_rdata[4]})); // R9
endmodule

bind field_detector fd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_lead   (hs_lead),
    .vs_trail  (vs_trail),
    .meas_cnt  (meas_cnt),
    .field_odd (field_odd),
    .dot_line  (dot_line),
    .reg_rdata (reg_rdata),
    .rgb_in    (rgb_in),
    .rgb_out   (rgb_out),
    .aux_in    (aux_in),
    .aux_out   (aux_out)
);

// File: tb/field_detector_test.sv
module field_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int CNT_MAX    = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       vsync_in = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [2:0] rgb_in = 3'b000;
    logic [1:0] aux_in = 2'b00;
    wire  [7:0] reg_rdata;
    wire        field_odd;
    wire        dot_line;
    wire  [2:0] rgb_out;
    wire  [1:0] aux_out;

    field_detector #(.CNT_W(CNT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_in  (hsync_in),
        .vsync_in  (vsync_in),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .field_odd (field_odd),
        .dot_line  (dot_line),
        .rgb_in    (rgb_in),
        .rgb_out   (rgb_out),
        .aux_in    (aux_in),
        .aux_out   (aux_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic  flag;
        string tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   n_run  = 0;
    int   n_fail = 0;
    logic m_flag   = 1'b1;
    int   m_stored = 0;
    logic m_dotsel = 1'b0;
    logic m_neg    = 1'b0;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(logic flag, string tag);
        exp_t e;
        e.flag = flag;
        e.tag  = tag;
        q.push_back(e);
        -> sample_ev;
    endtask

    task automatic write_reg(logic [7:0] v);
        reg_wdata = v;
        reg_we    = 1'b1;
        cyc(1);
        reg_we    = 1'b0;
        cyc(1);
    endtask

    // One field: active hsync edge, then active vsync edge delay cycles later.
    task automatic run_field(int delay, bit chk, string tag);
        logic act;
        int   meas;
        logic nxt;
        act = m_neg ? 1'b0 : 1'b1;
        hsync_in = act;
        cyc(4);
        hsync_in = ~act;
        cyc(delay - 4);
        vsync_in = act;
        cyc(5);
        if (chk) push_exp(m_flag, {"R4 flag held in vsync: ", tag});
        cyc(3);
        vsync_in = ~act;
        meas = (delay - 1 > CNT_MAX) ? CNT_MAX : delay - 1;
        if (meas > m_stored)      nxt = 1'b0;
        else if (meas < m_stored) nxt = 1'b1;
        else                      nxt = m_flag;
        m_stored = meas;
        m_flag   = nxt;
        cyc(6);
        if (chk) push_exp(m_flag, tag);
        cyc(4);
    endtask

    // Monitor: pops expected items and compares at the ports.
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                e = q.pop_front();
                check({e.tag, " (bit7)"}, {7'b0, reg_rdata[7]}, {7'b0, e.flag});
                check({e.tag, " (field_odd)"}, {7'b0, field_odd}, {7'b0, e.flag});
                check({"R6 dot_line: ", e.tag}, {7'b0, dot_line}, {7'b0, e.flag ^ m_dotsel});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL R4 watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        check("R7 reset value", reg_rdata, 8'h80);
        check("R5 reset flag odd", {7'b0, field_odd}, 8'h01);
        check("R6 reset dot_line", {7'b0, dot_line}, 8'h01);

        run_field(50, 1, "R3 longer than stored gives even");
        run_field(30, 1, "R3 shorter gives odd");
        run_field(30, 1, "R3 equal keeps odd");
        run_field(60, 1, "R2 R3 longer gives even");
        run_field(60, 1, "R3 equal keeps even");
        run_field(20, 1, "R2 shorter gives odd");

        run_field(300, 1, "R8 saturated longer gives even");
        run_field(400, 1, "R8 both saturated keep even");
        run_field(100, 1, "R8 below saturation gives odd");

        write_reg(8'h40);
        m_dotsel = 1'b1;
        check("R6 dot_line inverted by select", {7'b0, dot_line}, {7'b0, m_flag ^ 1'b1});
        check("R6 flag unaffected by select", reg_rdata, {m_flag, 7'h40});
        run_field(150, 1, "R6 select set, longer gives even");
        run_field(120, 1, "R6 select set, shorter gives odd");

        rgb_in = 3'b101;
        aux_in = 2'b01;
        cyc(1);
        check("R9 rgb positive", {5'b0, rgb_out}, 8'h05);
        check("R9 aux positive", {6'b0, aux_out}, 8'h01);
        write_reg(m_flag ? 8'h7F : 8'hFF);
        check("R5 R7 readback, bit7 write ignored, bit3 zero", reg_rdata, {m_flag, 7'b111_0111});
        check("R9 rgb inverted", {5'b0, rgb_out}, 8'h02);
        check("R9 aux inverted", {6'b0, aux_out}, 8'h02);

        hsync_in = 1'b1;
        vsync_in = 1'b1;
        cyc(10);
        m_neg = 1'b1;
        run_field(60, 0, "prime");
        m_flag   = reg_rdata[7];
        m_stored = 59;
        run_field(90, 1, "R1 active-low, longer gives even");
        run_field(45, 1, "R1 active-low, shorter gives odd");
        run_field(45, 1, "R1 active-low, equal keeps odd");

        cyc(5);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule